// File: doc/BRIEF.md
# In-Order Completion Buffer

This block tracks every instruction between dispatch and architectural completion. It is a circular buffer of sixteen entries. The dispatch stage asks for up to four entries per cycle and receives one tag per instruction, issued in program order. Execution units later report finished work by tag. The buffer retires finished entries from its oldest end, up to four per cycle, so the architected state always reflects a precise point in the program.

Each entry carries three pieces of state: a destination class, a branch marker and a resolved flag. Retirement stops early when the retiring group would need more register-file write ports of one class than the cycle allows. It also stops at any branch whose outcome is still unknown, which holds every younger instruction behind that branch. A branch resolve port marks a branch as known. When the branch was mispredicted, the same port discards every entry younger than it.

A small controller has two states. In `CB_RUN`, dispatch is accepted normally. A mispredict seen on the resolve port moves it to `CB_RECOVER`, and dispatch is refused for that one cycle. `CB_RECOVER` returns to `CB_RUN` on the next cycle, or stays in `CB_RECOVER` if another mispredict arrives. Dispatch is also refused in the cycle that carries the mispredict.

Top module: `completion_buffer`

## Requirements
- R1: After reset the buffer is empty: `cb_full` is 0, `ret_cnt` is 0, and the first allocated entry receives tag 0.
- R2: A request of `disp_cnt` entries that is accepted assigns consecutive tags, starting at the current tail, to lanes 0 to `disp_cnt`-1. Tags wrap modulo 16.
- R3: A request that needs more entries than are free is refused as a whole (`disp_stall`=1) and allocates nothing. `cb_full` is 1 when all 16 entries are in flight.
- R4: A finish port marks its entry finished. Finished entries retire from the head in program order, at most four per cycle, and are shown on `ret_cnt`/`ret_tags` in the cycle before the head advances. An unfinished entry blocks every younger entry.
- R5: Destination classes are encoded 2'b00 none, 2'b01 integer register, 2'b10 floating-point register, 2'b11 condition field. Each cycle at most 2 integer, 1 floating-point and 2 condition-field entries retire. Retirement stops at the first entry that would exceed its class budget.
- R6: A branch entry retires only after it is resolved on the resolve port. A finish report alone does not let it retire, and younger finished entries wait behind it.
- R7: At most four unresolved branches may be in flight. A request whose branches would raise that number to five is refused as a whole.
- R8: A mispredict discards every entry younger than the branch. The branch itself still retires, the next allocated tag is the branch tag plus one, and a discarded entry's finished state never lets the reused slot retire.
- R9: The controller goes from `CB_RUN` to `CB_RECOVER` on a mispredict. Dispatch is refused in the mispredict cycle and in the `CB_RECOVER` cycle, and is accepted again once the controller is back in `CB_RUN`.
- R10: A finish report for a tag that is not in flight has no effect. The entry later allocated under that tag does not retire until it is finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_cnt | input | 3 | Number of entries requested this cycle (0 to 4) |
| disp_br | input | 4 | Per-lane flag: instruction is a predicted branch |
| disp_cls | input | 8 | Per-lane destination class, lane k in bits 2k+1:2k |
| disp_stall | output | 1 | Request refused this cycle |
| disp_tags | output | 16 | Tag for lane k in bits 4k+3:4k |
| cb_full | output | 1 | All entries in flight |
| fin_valid | input | 4 | Finish report valid, one bit per port |
| fin_tags | input | 16 | Finish tag for port k in bits 4k+3:4k |
| res_valid | input | 1 | Branch resolve report valid |
| res_mispredict | input | 1 | Resolved branch was mispredicted |
| res_tag | input | 4 | Tag of the resolved branch |
| ret_cnt | output | 3 | Entries retiring this cycle |
| ret_tags | output | 16 | Tag of retiring slot k in bits 4k+3:4k |

## Verification
The bench fills all sixteen entries and then asks for one more and for two more when one slot is free. A buffer that overwrote live entries, or accepted part of a group, would hand out a tag that is already in use. It sends class mixes that exceed the integer, floating-point and condition budgets at different lanes. A selector that skipped an over-budget entry instead of stopping would retire out of order. It finishes a branch through a finish port without resolving it, which catches a buffer that lets unresolved branches or their younger entries leave. After a mispredict it reallocates a slot that held a finished, squashed entry. A design that kept stale finished state would retire the new instruction at once, and a design without the recovery cycle would accept dispatch too early.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;

    // Destination register class recorded per entry
    typedef enum logic [1:0] {
        DC_NONE = 2'b00,
        DC_GPR  = 2'b01,
        DC_FPR  = 2'b10,
        DC_CRF  = 2'b11
    } dclass_t;

    // Controller states
    typedef enum logic {
        CB_RUN     = 1'b0,
        CB_RECOVER = 1'b1
    } cb_state_e;

endpackage

// File: rtl/cbuf_alloc_ctl.sv
module cbuf_alloc_ctl #(
    parameter int DEPTH  = 16,
    parameter int DISP_W = 4,
    parameter int MAX_BR = 4,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int DC_W   = $clog2(DISP_W + 1),
    parameter int OCC_W  = IDX_W + 1
) (
    input  logic [OCC_W-1:0]        occ,
    input  logic [OCC_W-1:0]        unres,
    input  logic [IDX_W-1:0]        tail_idx,
    input  logic [DC_W-1:0]         disp_cnt,
    input  logic [DISP_W-1:0]       disp_br,
    input  logic                    disp_open,
    output logic                    disp_stall,
    output logic                    disp_take,
    output logic [DISP_W*IDX_W-1:0] disp_tags
);

    int  new_br;
    logic over_cap;
    logic over_br;

    // Count branches among the requested lanes and check both limits
    always_comb begin
        new_br = 0;
        for (int i = 0; i < DISP_W; i++) begin
            if (i < int'(disp_cnt) && disp_br[i]) begin
                new_br = new_br + 1;
            end
        end
        over_cap   = int'(disp_cnt) > (DEPTH - int'(occ));
        over_br    = (int'(unres) + new_br) > MAX_BR;
        disp_stall = (disp_cnt != '0) && (!disp_open || over_cap || over_br);
        disp_take  = (disp_cnt != '0) && !disp_stall;
    end

    for (genvar gl = 0; gl < DISP_W; gl++) begin : g_tag
        assign disp_tags[gl*IDX_W +: IDX_W] = tail_idx + IDX_W'(gl);
    end

endmodule

// File: rtl/cbuf_retire_sel.sv
module cbuf_retire_sel
    import cbuf_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int RET_W     = 4,
    parameter int GPR_PORTS = 2,
    parameter int FPR_PORTS = 1,
    parameter int CRF_PORTS = 2,
    parameter int IDX_W     = $clog2(DEPTH),
    parameter int OCC_W     = IDX_W + 1,
    parameter int RC_W      = $clog2(RET_W + 1)
) (
    input  logic [IDX_W-1:0]           head_idx,
    input  logic [OCC_W-1:0]           occ,
    input  logic [DEPTH-1:0]           e_fin,
    input  logic [DEPTH-1:0]           e_br,
    input  logic [DEPTH-1:0]           e_res,
    input  logic [DEPTH-1:0][1:0]      e_cls,
    output logic [RC_W-1:0]            ret_cnt,
    output logic [RET_W*IDX_W-1:0]     ret_tags
);

    // Walk the oldest RET_W slots; stop at the first one that cannot leave
    always_comb begin
        logic             go;
        logic [IDX_W-1:0] idx;
        int               n_gpr;
        int               n_fpr;
        int               n_crf;
        go       = 1'b1;
        n_gpr    = 0;
        n_fpr    = 0;
        n_crf    = 0;
        ret_cnt  = '0;
        ret_tags = '0;
        for (int k = 0; k < RET_W; k++) begin
            idx = head_idx + IDX_W'(k);
            ret_tags[k*IDX_W +: IDX_W] = idx;
            if (go) begin
                if (OCC_W'(k) >= occ || !e_fin[idx] || (e_br[idx] && !e_res[idx])) begin
                    go = 1'b0;
                end else begin
                    case (dclass_t'(e_cls[idx]))
                        DC_GPR:  if (n_gpr >= GPR_PORTS) go = 1'b0; else n_gpr = n_gpr + 1;
                        DC_FPR:  if (n_fpr >= FPR_PORTS) go = 1'b0; else n_fpr = n_fpr + 1;
                        DC_CRF:  if (n_crf >= CRF_PORTS) go = 1'b0; else n_crf = n_crf + 1;
                        default: ;
                    endcase
                end
                if (go) begin
                    ret_cnt = ret_cnt + RC_W'(1);
                end
            end
        end
    end

    // R5: per-class budget is never exceeded by the retiring group
    always_comb begin
        int c_gpr;
        int c_fpr;
        int c_crf;
        c_gpr = 0;
        c_fpr = 0;
        c_crf = 0;
        for (int k = 0; k < RET_W; k++) begin
            if (k < int'(ret_cnt)) begin
                case (dclass_t'(e_cls[head_idx + IDX_W'(k)]))
                    DC_GPR:  c_gpr = c_gpr + 1;
                    DC_FPR:  c_fpr = c_fpr + 1;
                    DC_CRF:  c_crf = c_crf + 1;
                    default: ;
                endcase
            end
        end
        a_r5_port_budget: assert (c_gpr <= GPR_PORTS && c_fpr <= FPR_PORTS && c_crf <= CRF_PORTS);
    end

endmodule

// File: rtl/completion_buffer.sv
module completion_buffer
    import cbuf_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int DISP_W    = 4,
    parameter int RET_W     = 4,
    parameter int FIN_W     = 4,
    parameter int MAX_BR    = 4,
    parameter int GPR_PORTS = 2,
    parameter int FPR_PORTS = 1,
    parameter int CRF_PORTS = 2,
    parameter int IDX_W     = $clog2(DEPTH),
    parameter int DC_W      = $clog2(DISP_W + 1),
    parameter int RC_W      = $clog2(RET_W + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DC_W-1:0]         disp_cnt,
    input  logic [DISP_W-1:0]       disp_br,
    input  logic [2*DISP_W-1:0]     disp_cls,
    output logic                    disp_stall,
    output logic [DISP_W*IDX_W-1:0] disp_tags,
    output logic                    cb_full,
    input  logic [FIN_W-1:0]        fin_valid,
    input  logic [FIN_W*IDX_W-1:0]  fin_tags,
    input  logic                    res_valid,
    input  logic                    res_mispredict,
    input  logic [IDX_W-1:0]        res_tag,
    output logic [RC_W-1:0]         ret_cnt,
    output logic [RET_W*IDX_W-1:0]  ret_tags
);

    localparam int PTR_W = IDX_W + 1;
    localparam int OCC_W = IDX_W + 1;

    // Pointers carry a wrap bit above the slot index
    logic [PTR_W-1:0]         head_q;
    logic [PTR_W-1:0]         tail_q;
    logic [OCC_W-1:0]         occ;
    logic [DEPTH-1:0]         live;
    logic [DEPTH-1:0]         e_fin;
    logic [DEPTH-1:0]         e_br;
    logic [DEPTH-1:0]         e_res;
    logic [DEPTH-1:0][1:0]    e_cls;
    logic [OCC_W-1:0]         unres;
    logic [IDX_W-1:0]         head_idx;
    logic [IDX_W-1:0]         tail_idx;
    logic [IDX_W-1:0]         res_age;
    logic                     res_hit;
    logic                     flush_now;
    logic                     disp_open;
    logic                     disp_take;
    cb_state_e                st_q;
    cb_state_e                st_d;

    assign head_idx = head_q[IDX_W-1:0];
    assign tail_idx = tail_q[IDX_W-1:0];
    assign occ      = tail_q - head_q;
    assign cb_full  = (occ == OCC_W'(DEPTH));
    assign res_age  = res_tag - head_idx;

    // A slot is in flight when its distance from the head is below occupancy
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_live
        logic [IDX_W-1:0] age;
        assign age      = IDX_W'(gi) - head_idx;
        assign live[gi] = {1'b0, age} < occ;
    end

    assign res_hit   = res_valid && live[res_tag] && e_br[res_tag];
    assign flush_now = res_hit && res_mispredict;

    // Unresolved branches currently in flight
    always_comb begin
        unres = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (live[i] && e_br[i] && !e_res[i]) begin
                unres = unres + OCC_W'(1);
            end
        end
    end

    // ---------------- controller ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CB_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CB_RUN:     if (flush_now) st_d = CB_RECOVER;
            CB_RECOVER: st_d = flush_now ? CB_RECOVER : CB_RUN;
        endcase
    end

    always_comb begin
        disp_open = 1'b0;
        unique case (st_q)
            CB_RUN:     disp_open = !flush_now;
            CB_RECOVER: disp_open = 1'b0;
        endcase
    end

    // ---------------- allocation and retirement ----------------
    cbuf_alloc_ctl #(
        .DEPTH  (DEPTH),
        .DISP_W (DISP_W),
        .MAX_BR (MAX_BR),
        .IDX_W  (IDX_W),
        .DC_W   (DC_W),
        .OCC_W  (OCC_W)
    ) u_alloc (
        .occ        (occ),
        .unres      (unres),
        .tail_idx   (tail_idx),
        .disp_cnt   (disp_cnt),
        .disp_br    (disp_br),
        .disp_open  (disp_open),
        .disp_stall (disp_stall),
        .disp_take  (disp_take),
        .disp_tags  (disp_tags)
    );

    cbuf_retire_sel #(
        .DEPTH     (DEPTH),
        .RET_W     (RET_W),
        .GPR_PORTS (GPR_PORTS),
        .FPR_PORTS (FPR_PORTS),
        .CRF_PORTS (CRF_PORTS),
        .IDX_W     (IDX_W),
        .OCC_W     (OCC_W),
        .RC_W      (RC_W)
    ) u_retire (
        .head_idx (head_idx),
        .occ      (occ),
        .e_fin    (e_fin),
        .e_br     (e_br),
        .e_res    (e_res),
        .e_cls    (e_cls),
        .ret_cnt  (ret_cnt),
        .ret_tags (ret_tags)
    );

    // ---------------- entry state and pointers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            e_fin  <= '0;
            e_br   <= '0;
            e_res  <= '0;
            e_cls  <= '0;
        end else begin
            for (int f = 0; f < FIN_W; f++) begin
                if (fin_valid[f] && live[fin_tags[f*IDX_W +: IDX_W]]) begin
                    e_fin[fin_tags[f*IDX_W +: IDX_W]] <= 1'b1;
                end
            end
            if (res_hit) begin
                e_res[res_tag] <= 1'b1;
                e_fin[res_tag] <= 1'b1;
            end
            head_q <= head_q + PTR_W'(ret_cnt);
            if (flush_now) begin
                tail_q <= head_q + {1'b0, res_age} + PTR_W'(1);
            end else if (disp_take) begin
                for (int i = 0; i < DISP_W; i++) begin
                    if (i < int'(disp_cnt)) begin
                        e_fin[tail_idx + IDX_W'(i)] <= 1'b0;
                        e_res[tail_idx + IDX_W'(i)] <= 1'b0;
                        e_br[tail_idx + IDX_W'(i)]  <= disp_br[i];
                        e_cls[tail_idx + IDX_W'(i)] <= disp_cls[2*i +: 2];
                    end
                end
                tail_q <= tail_q + PTR_W'(disp_cnt);
            end
        end
    end

    // ---------------- assertions ----------------
    a_r1_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(DEPTH));

    a_r3_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (cb_full && disp_cnt != '0) |-> disp_stall);

    a_r4_ret_within_occ: assert property (@(posedge clk) disable iff (!rst_n)
        OCC_W'(ret_cnt) <= occ);

    a_r4_head_finished: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_cnt != '0) |-> e_fin[head_idx]);

    a_r6_branch_resolved: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_cnt != '0 && e_br[head_idx]) |-> e_res[head_idx]);

    a_r7_branch_cap: assert property (@(posedge clk) disable iff (!rst_n)
        unres <= OCC_W'(MAX_BR));

    a_r9_enter_recover: assert property (@(posedge clk) disable iff (!rst_n)
        flush_now |=> (st_q == CB_RECOVER));

    a_r9_recover_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CB_RECOVER && disp_cnt != '0) |-> disp_stall);

endmodule

// File: tb/sim_completion_buffer.sv
module sim_completion_buffer;

    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic [2:0]  disp_cnt;
    logic [3:0]  disp_br;
    logic [7:0]  disp_cls;
    logic        disp_stall;
    logic [15:0] disp_tags;
    logic        cb_full;
    logic [3:0]  fin_valid;
    logic [15:0] fin_tags;
    logic        res_valid;
    logic        res_mispredict;
    logic [3:0]  res_tag;
    logic [2:0]  ret_cnt;
    logic [15:0] ret_tags;

    int checks = 0;
    int errors = 0;
    int tl     = 0;

    completion_buffer u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .disp_cnt       (disp_cnt),
        .disp_br        (disp_br),
        .disp_cls       (disp_cls),
        .disp_stall     (disp_stall),
        .disp_tags      (disp_tags),
        .cb_full        (cb_full),
        .fin_valid      (fin_valid),
        .fin_tags       (fin_tags),
        .res_valid      (res_valid),
        .res_mispredict (res_mispredict),
        .res_tag        (res_tag),
        .ret_cnt        (ret_cnt),
        .ret_tags       (ret_tags)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk_eq(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic int rtag(input int k);
        return int'(ret_tags[k*4 +: 4]);
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_disp(input int n, input logic [3:0] brm, input logic [7:0] cls,
                           output int stl, output int t0);
        disp_cnt = 3'(n);
        disp_br  = brm;
        disp_cls = cls;
        #1;
        stl = int'(disp_stall);
        t0  = int'(disp_tags[3:0]);
        if (!disp_stall) begin
            for (int k = 1; k < n; k++) begin
                chk_eq("R2 lane tag consecutive", int'(disp_tags[k*4 +: 4]), (t0 + k) % 16);
            end
        end
        @(negedge clk);
        disp_cnt = '0;
        disp_br  = '0;
        disp_cls = '0;
    endtask

    task automatic do_fin(input int n, input int start);
        for (int k = 0; k < 4; k++) begin
            fin_valid[k]       = (k < n);
            fin_tags[k*4 +: 4] = 4'((start + k) % 16);
        end
        @(negedge clk);
        fin_valid = '0;
    endtask

    task automatic do_res(input int tag, input logic mis);
        res_valid      = 1'b1;
        res_mispredict = mis;
        res_tag        = 4'(tag % 16);
        @(negedge clk);
        res_valid      = 1'b0;
        res_mispredict = 1'b0;
    endtask

    task automatic drain(input int start, input int n);
        for (int i = 0; i < n; i += 4) begin
            do_fin((n - i) < 4 ? (n - i) : 4, start + i);
        end
        idle(6);
    endtask

    // R1, R2, R4: reset state, first tags, in-order retirement
    task automatic t_reset_and_order();
        int s, t0;
        chk_eq("R1 cb_full after reset", int'(cb_full), 0);
        chk_eq("R1 ret_cnt after reset", int'(ret_cnt), 0);
        do_disp(3, 4'b0000, 8'h00, s, t0);
        chk_eq("R2 first request accepted", s, 0);
        chk_eq("R1 first tag is zero", t0, 0);
        tl = 3;
        do_fin(1, 1);
        chk_eq("R4 younger waits behind unfinished head", int'(ret_cnt), 0);
        do_fin(1, 0);
        chk_eq("R4 two retire together", int'(ret_cnt), 2);
        chk_eq("R4 oldest tag first", rtag(0), 0);
        chk_eq("R4 second tag", rtag(1), 1);
        do_fin(1, 2);
        chk_eq("R4 last entry retires", int'(ret_cnt), 1);
        chk_eq("R4 last entry tag", rtag(0), 2);
        idle(1);
    endtask

    // R3, R2 wrap: fill, refuse, partial refusal
    task automatic t_full();
        int s, t0, base;
        base = tl;
        for (int g = 0; g < 4; g++) begin
            do_disp(4, 4'b0000, 8'h00, s, t0);
            chk_eq("R3 fill accepted", s, 0);
            chk_eq("R2 group tag wraps", t0, tl % 16);
            tl += 4;
        end
        chk_eq("R3 cb_full at 16", int'(cb_full), 1);
        do_disp(1, 4'b0000, 8'h00, s, t0);
        chk_eq("R3 stall when full", s, 1);
        do_fin(1, base);
        idle(1);
        do_disp(2, 4'b0000, 8'h00, s, t0);
        chk_eq("R3 group larger than free space refused", s, 1);
        do_disp(1, 4'b0000, 8'h00, s, t0);
        chk_eq("R3 single fits", s, 0);
        chk_eq("R3 refused requests allocated nothing", t0, tl % 16);
        tl += 1;
        chk_eq("R3 full again", int'(cb_full), 1);
        drain(base + 1, 16);
        chk_eq("R3 empty after drain", int'(cb_full), 0);
    endtask

    // R5: class budget case
    task automatic t_budget(input logic [7:0] cls, input int e1, input int e2);
        int s, t0;
        do_disp(4, 4'b0000, cls, s, t0);
        chk_eq("R5 request accepted", s, 0);
        do_fin(4, t0);
        chk_eq("R5 first retire group size", int'(ret_cnt), e1);
        chk_eq("R5 first retire tag", rtag(0), t0);
        idle(1);
        chk_eq("R5 second retire group size", int'(ret_cnt), e2);
        chk_eq("R5 second retire tag", rtag(0), (t0 + e1) % 16);
        idle(2);
        tl += 4;
    endtask

    // R6: unresolved branch holds itself and younger entries
    task automatic t_branch_hold();
        int s, t0;
        do_disp(3, 4'b0001, 8'h00, s, t0);
        chk_eq("R6 request accepted", s, 0);
        do_fin(3, t0);
        chk_eq("R6 finished branch without resolve stays", int'(ret_cnt), 0);
        idle(1);
        chk_eq("R6 still held next cycle", int'(ret_cnt), 0);
        do_res(t0, 1'b0);
        chk_eq("R6 resolve releases all three", int'(ret_cnt), 3);
        idle(2);
        tl += 3;
    endtask

    // R7: four unresolved branches maximum
    task automatic t_branch_limit();
        int s, t0, nb, bn;
        do_disp(4, 4'b1111, 8'h00, s, t0);
        chk_eq("R7 four branches accepted", s, 0);
        tl += 4;
        do_disp(1, 4'b0001, 8'h00, s, nb);
        chk_eq("R7 fifth branch stalls", s, 1);
        do_disp(1, 4'b0000, 8'h00, s, nb);
        chk_eq("R7 non-branch still accepted", s, 0);
        chk_eq("R7 non-branch tag", nb, tl % 16);
        tl += 1;
        do_res(t0, 1'b0);
        chk_eq("R7 resolved oldest branch retires", int'(ret_cnt), 1);
        do_disp(1, 4'b0001, 8'h00, s, bn);
        chk_eq("R7 branch accepted after one resolves", s, 0);
        tl += 1;
        do_res(t0 + 1, 1'b0);
        do_res(t0 + 2, 1'b0);
        do_res(t0 + 3, 1'b0);
        do_fin(1, nb);
        do_res(bn, 1'b0);
        idle(4);
    endtask

    // R8, R9: mispredict squash and recovery cycle
    task automatic t_mispredict();
        int s, t0, tn;
        do_disp(4, 4'b0010, 8'h00, s, t0);
        chk_eq("R8 request accepted", s, 0);
        do_fin(1, t0);
        do_fin(2, t0 + 2);
        res_valid      = 1'b1;
        res_mispredict = 1'b1;
        res_tag        = 4'((t0 + 1) % 16);
        disp_cnt       = 3'd1;
        #1;
        chk_eq("R9 dispatch refused in mispredict cycle", int'(disp_stall), 1);
        @(negedge clk);
        res_valid      = 1'b0;
        res_mispredict = 1'b0;
        disp_cnt       = '0;
        chk_eq("R8 only the branch retires", int'(ret_cnt), 1);
        chk_eq("R8 retiring tag is the branch", rtag(0), (t0 + 1) % 16);
        do_disp(1, 4'b0000, 8'h00, s, tn);
        chk_eq("R9 dispatch refused in recover state", s, 1);
        do_disp(1, 4'b0000, 8'h00, s, tn);
        chk_eq("R9 dispatch accepted back in run state", s, 0);
        chk_eq("R8 next tag follows branch", tn, (t0 + 2) % 16);
        chk_eq("R8 reused slot not finished", int'(ret_cnt), 0);
        do_fin(1, tn);
        chk_eq("R8 reused slot retires after finish", int'(ret_cnt), 1);
        idle(2);
        tl = t0 + 3;
    endtask

    // R10: finish for a tag not in flight is ignored
    task automatic t_stray_finish();
        int s, t0;
        do_fin(1, tl);
        idle(1);
        do_disp(1, 4'b0000, 8'h00, s, t0);
        chk_eq("R10 request accepted", s, 0);
        chk_eq("R10 tag is the stray slot", t0, tl % 16);
        chk_eq("R10 stray finish had no effect", int'(ret_cnt), 0);
        do_fin(1, tl + 5);
        chk_eq("R10 finish beyond tail ignored", int'(ret_cnt), 0);
        do_fin(1, tl);
        chk_eq("R10 retires after real finish", int'(ret_cnt), 1);
        idle(2);
        tl += 1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n          = 1'b0;
        disp_cnt       = '0;
        disp_br        = '0;
        disp_cls       = '0;
        fin_valid      = '0;
        fin_tags       = '0;
        res_valid      = 1'b0;
        res_mispredict = 1'b0;
        res_tag        = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_and_order();
        t_full();
        t_budget(8'b10_01_01_01, 2, 2);
        t_budget(8'b00_11_10_10, 1, 3);
        t_budget(8'b01_11_11_11, 2, 2);
        t_branch_hold();
        t_branch_limit();
        t_mispredict();
        t_stray_finish();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule